// File: doc/BRIEF.md
# System-Management Interrupt Router

The router gathers single-cycle system-management event pulses from five source groups into sticky status bits: hardware traps, SMBus, GPIO pins, miscellaneous sources, and LPT/USB. Every status bit has two enable masks. The first, the ACPI mask, feeds one combined ACPI request. A control bit steers that request to either the SCI line or the SMI line. The second mask, the direct-SMI mask, feeds the SMI line whatever the steering bit says. Two external SMI requests, one from USB keyboard emulation and one from serial-IRQ logic, are merged into SMI. A global gate bit masks the whole SMI output.

Software reaches the status, mask and control registers through a flat port with an 8-bit address and 16-bit data. Writes take effect in one cycle. Read data appears one cycle after the read strobe. Status bits clear only when software writes a 1 to them.

Top module: `acpi_irq_router`

## Requirements
- R1: After reset, every status, mask and control register reads 0, and both sci_o and smi_o are low.
- R2: A pulse on evt_i bit g*16+b sets status bit b of group g. The bit stays set after the pulse ends. Group g's status register sits at address ((g+1)<<4)|0.
- R3: A write to a status register clears each bit where wdata_i holds 1 and leaves each bit where it holds 0.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set. Other bits cleared by that write still clear.
- R5: Control register (address 0x00) bit 0 is the steering bit and bit 1 is the SMI gate. When the steering bit is 1, sci_o is high while any status bit and its ACPI mask bit (group offset 1) are both set.
- R6: When the steering bit is 0, sci_o stays low. The ACPI request then drives smi_o instead, provided the SMI gate is 1.
- R7: A status bit set together with its direct-SMI mask bit (group offset 2) drives smi_o high for either value of the steering bit, provided the SMI gate is 1.
- R8: usb_smi_i or serirq_smi_i high drives smi_o high in the same cycle, provided the SMI gate is 1.
- R9: With the SMI gate at 0, smi_o is low whatever the status bits and external requests are.
- R10: rdata_o presents the addressed register one cycle after rd_en_i. Mask and control registers read back what was written. Unmapped addresses read 0.
- R11: A set status bit whose two mask bits are both 0 leaves sci_o and smi_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid one cycle after rd_en_i |
| evt_i | input | 80 | Event pulses, 16 per group, group g at bits g*16 and up |
| usb_smi_i | input | 1 | External SMI request from USB keyboard emulation |
| serirq_smi_i | input | 1 | External SMI request from serial-IRQ logic |
| sci_o | output | 1 | SCI level output |
| smi_o | output | 1 | SMI level output |

## Verification
Two things can land on the same status bit in one clock: a new event pulse and a software clear of that bit. The bench provokes this by raising the event and the clearing write on the same falling edge. It also clears a second bit with the same write. It then reads the status register back and expects the collided bit to be set and the other bit to be clear. A second overlap is the direct-SMI path and the steered ACPI path both driving smi_o. The bench checks that the steering bit never lets SCI assert while SMI is the chosen target.

// File: rtl/acpi_irq_pkg.sv
package acpi_irq_pkg;
  parameter int NUM_GRP = 5;
  parameter int DW      = 16;
  parameter int AW      = 8;

  localparam int EVT_W = NUM_GRP * DW;

  typedef enum logic [3:0] {
    OFS_STAT = 4'h0,
    OFS_AEN  = 4'h1,
    OFS_SEN  = 4'h2
  } grp_ofs_e;

  typedef enum int {
    GRP_TRAP    = 0,
    GRP_SMBUS   = 1,
    GRP_GPIO    = 2,
    GRP_MISC    = 3,
    GRP_LPT_USB = 4
  } grp_id_e;

  localparam logic [AW-1:0] CTRL_ADDR = '0;
  localparam int CTRL_W = 2;
endpackage

// File: rtl/acpi_evt_group.sv
module acpi_evt_group #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] evt_i,
  input  logic          clr_we_i,
  input  logic          aen_we_i,
  input  logic          sen_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] aen_o,
  output logic [DW-1:0] sen_o,
  output logic          acpi_req_o,
  output logic          smi_req_o
);
  logic [DW-1:0] stat_q, aen_q, sen_q;
  logic [DW-1:0] clr_mask;

  assign clr_mask = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      aen_q  <= '0;
      sen_q  <= '0;
    end else begin
      // event set dominates a same-cycle clear
      stat_q <= (stat_q & ~clr_mask) | evt_i;
      if (aen_we_i) aen_q <= wdata_i;
      if (sen_we_i) sen_q <= wdata_i;
    end
  end

  assign stat_o     = stat_q;
  assign aen_o      = aen_q;
  assign sen_o      = sen_q;
  assign acpi_req_o = |(stat_q & aen_q);
  assign smi_req_o  = |(stat_q & sen_q);
endmodule

// File: rtl/acpi_irq_route.sv
module acpi_irq_route #(
  parameter int NUM_GRP = 5
) (
  input  logic [NUM_GRP-1:0] acpi_req_i,
  input  logic [NUM_GRP-1:0] smi_req_i,
  input  logic               sci_sel_i,
  input  logic               smi_gate_i,
  input  logic               usb_smi_i,
  input  logic               serirq_smi_i,
  output logic               sci_o,
  output logic               smi_o
);
  logic acpi_any, direct_any, smi_raw;

  assign acpi_any   = |acpi_req_i;
  assign direct_any = |smi_req_i;
  assign sci_o      = sci_sel_i & acpi_any;
  assign smi_raw    = (~sci_sel_i & acpi_any) | direct_any | usb_smi_i | serirq_smi_i;
  assign smi_o      = smi_gate_i & smi_raw;
endmodule

// File: rtl/acpi_irq_router.sv
module acpi_irq_router
  import acpi_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             usb_smi_i,
  input  logic             serirq_smi_i,
  output logic             sci_o,
  output logic             smi_o
);
  logic [NUM_GRP-1:0]       acpi_req, smi_req;
  logic [DW-1:0]            stat_a [NUM_GRP];
  logic [DW-1:0]            aen_a  [NUM_GRP];
  logic [DW-1:0]            sen_a  [NUM_GRP];
  logic [EVT_W-1:0]         stat_all;
  logic [CTRL_W-1:0]        ctrl_q;
  logic                     sci_sel, smi_gate;
  logic [3:0]               region;
  logic [3:0]               ofs;
  logic [DW-1:0]            rd_mux;
  logic [DW-1:0]            rdata_q;

  assign region   = addr_i[7:4];
  assign ofs      = addr_i[3:0];
  assign sci_sel  = ctrl_q[0];
  assign smi_gate = ctrl_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              ctrl_q <= '0;
    else if (wr_en_i && addr_i == CTRL_ADDR)  ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic hit;
    assign hit = (region == 4'(g + 1));
    acpi_evt_group #(.DW(DW)) u_grp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_i[g*DW +: DW]),
      .clr_we_i   (wr_en_i && hit && ofs == OFS_STAT),
      .aen_we_i   (wr_en_i && hit && ofs == OFS_AEN),
      .sen_we_i   (wr_en_i && hit && ofs == OFS_SEN),
      .wdata_i    (wdata_i),
      .stat_o     (stat_a[g]),
      .aen_o      (aen_a[g]),
      .sen_o      (sen_a[g]),
      .acpi_req_o (acpi_req[g]),
      .smi_req_o  (smi_req[g])
    );
    assign stat_all[g*DW +: DW] = stat_a[g];
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == CTRL_ADDR) rd_mux = DW'(ctrl_q);
    for (int g = 0; g < NUM_GRP; g++) begin
      if (region == 4'(g + 1)) begin
        case (ofs)
          OFS_STAT: rd_mux = stat_a[g];
          OFS_AEN:  rd_mux = aen_a[g];
          OFS_SEN:  rd_mux = sen_a[g];
          default:  rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  acpi_irq_route #(.NUM_GRP(NUM_GRP)) u_route (
    .acpi_req_i   (acpi_req),
    .smi_req_i    (smi_req),
    .sci_sel_i    (sci_sel),
    .smi_gate_i   (smi_gate),
    .usb_smi_i    (usb_smi_i),
    .serirq_smi_i (serirq_smi_i),
    .sci_o        (sci_o),
    .smi_o        (smi_o)
  );
endmodule

// File: rtl/acpi_irq_router_chk.sv
module acpi_irq_router_chk
  import acpi_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_en_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    rdata_o,
  input logic [EVT_W-1:0] evt_i,
  input logic [EVT_W-1:0] stat_all,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic             usb_smi_i,
  input logic             serirq_smi_i,
  input logic             sci_o,
  input logic             smi_o
);
  // R2 / R4: every pulsed bit is set on the next cycle
  a_r2_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((stat_all & $past(evt_i)) == $past(evt_i)));

  a_r6_sci_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[0] |-> !sci_o);

  a_r8_ext_smi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[1] && (usb_smi_i || serirq_smi_i)) |-> smi_o);

  a_r9_smi_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[1] |-> !smi_o);

  a_r10_ctrl_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == CTRL_ADDR) |=> (rdata_o == DW'($past(ctrl_q))));

  a_r11_no_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_all == '0 && !usb_smi_i && !serirq_smi_i) |-> (!sci_o && !smi_o));
endmodule

bind acpi_irq_router acpi_irq_router_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_en_i      (rd_en_i),
  .addr_i       (addr_i),
  .rdata_o      (rdata_o),
  .evt_i        (evt_i),
  .stat_all     (stat_all),
  .ctrl_q       (ctrl_q),
  .usb_smi_i    (usb_smi_i),
  .serirq_smi_i (serirq_smi_i),
  .sci_o        (sci_o),
  .smi_o        (smi_o)
);

// File: tb/tb_acpi_irq_router.sv
module tb_acpi_irq_router;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [79:0] evt_i = '0;
  logic        usb_smi_i = 1'b0, serirq_smi_i = 1'b0;
  logic        sci_o, smi_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  acpi_irq_router dut (.*);

  function automatic logic [7:0] ga(int g, int o);
    return 8'(((g + 1) << 4) | o);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic pulse(int g, int b);
    @(negedge clk_i);
    evt_i[g*16+b] = 1'b1;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 sci", 16'(sci_o), 16'h0);
    chk("R1 smi", 16'(smi_o), 16'h0);
    rd(8'h00, d); chk("R1 ctrl", d, 16'h0);
    for (int g = 0; g < 5; g++)
      for (int o = 0; o < 3; o++) begin
        rd(ga(g, o), d); chk("R1 reg", d, 16'h0);
      end
  endtask

  task automatic t_sticky();
    logic [15:0] d;
    pulse(2, 5);
    rd(ga(2, 0), d); chk("R2 set", d, 16'h0020);
    repeat (3) @(negedge clk_i);
    rd(ga(2, 0), d); chk("R2 sticky", d, 16'h0020);
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    wr(ga(2, 0), 16'h0000);
    rd(ga(2, 0), d); chk("R3 zero write keeps", d, 16'h0020);
    wr(ga(2, 0), 16'h0020);
    rd(ga(2, 0), d); chk("R3 one clears", d, 16'h0000);
  endtask

  task automatic t_collision();
    logic [15:0] d;
    pulse(1, 3);
    pulse(1, 4);
    @(negedge clk_i);
    evt_i[1*16+3] = 1'b1;
    wr_en_i = 1'b1; addr_i = ga(1, 0); wdata_i = 16'h0018;
    @(negedge clk_i);
    evt_i = '0; wr_en_i = 1'b0;
    rd(ga(1, 0), d); chk("R4 event wins", d, 16'h0008);
    wr(ga(1, 0), 16'hFFFF);
    rd(ga(1, 0), d); chk("R3 full clear", d, 16'h0000);
  endtask

  task automatic t_sci_route();
    wr(8'h00, 16'h0003);
    wr(ga(0, 1), 16'h0001);
    pulse(0, 0);
    chk("R5 sci high", 16'(sci_o), 16'h1);
    chk("R5 smi low", 16'(smi_o), 16'h0);
    wr(ga(0, 0), 16'h0001);
    chk("R5 sci drops", 16'(sci_o), 16'h0);
  endtask

  task automatic t_smi_steer();
    wr(8'h00, 16'h0002);
    pulse(0, 0);
    chk("R6 sci low", 16'(sci_o), 16'h0);
    chk("R6 smi high", 16'(smi_o), 16'h1);
    wr(ga(0, 0), 16'h0001);
    chk("R6 smi drops", 16'(smi_o), 16'h0);
    wr(ga(0, 1), 16'h0000);
  endtask

  task automatic t_smi_direct();
    wr(8'h00, 16'h0003);
    wr(ga(4, 2), 16'h8000);
    pulse(4, 15);
    chk("R7 smi sel1", 16'(smi_o), 16'h1);
    chk("R7 sci low", 16'(sci_o), 16'h0);
    wr(8'h00, 16'h0002);
    chk("R7 smi sel0", 16'(smi_o), 16'h1);
    wr(8'h00, 16'h0001);
    chk("R9 gate blocks direct", 16'(smi_o), 16'h0);
    wr(ga(4, 0), 16'h8000);
    wr(ga(4, 2), 16'h0000);
  endtask

  task automatic t_ext();
    wr(8'h00, 16'h0002);
    @(negedge clk_i); usb_smi_i = 1'b1; #1;
    chk("R8 usb", 16'(smi_o), 16'h1);
    @(negedge clk_i); usb_smi_i = 1'b0; serirq_smi_i = 1'b1; #1;
    chk("R8 serirq", 16'(smi_o), 16'h1);
    wr(8'h00, 16'h0000);
    chk("R9 gate blocks ext", 16'(smi_o), 16'h0);
    @(negedge clk_i); serirq_smi_i = 1'b0; #1;
    chk("R8 idle", 16'(smi_o), 16'h0);
  endtask

  task automatic t_no_enable();
    logic [15:0] d;
    wr(8'h00, 16'h0003);
    pulse(3, 7);
    rd(ga(3, 0), d); chk("R11 status set", d, 16'h0080);
    chk("R11 sci", 16'(sci_o), 16'h0);
    chk("R11 smi", 16'(smi_o), 16'h0);
    wr(ga(3, 0), 16'h0080);
  endtask

  task automatic t_readback();
    logic [15:0] d;
    wr(ga(2, 1), 16'hA5A5);
    wr(ga(2, 2), 16'h5A5A);
    rd(ga(2, 1), d); chk("R10 acpi mask", d, 16'hA5A5);
    rd(ga(2, 2), d); chk("R10 smi mask", d, 16'h5A5A);
    rd(8'h00, d); chk("R10 ctrl", d, 16'h0003);
    rd(8'h03, d); chk("R10 unmapped 03", d, 16'h0000);
    rd(8'h13, d); chk("R10 unmapped 13", d, 16'h0000);
    rd(8'h70, d); chk("R10 unmapped 70", d, 16'h0000);
    wr(ga(2, 1), 16'h0000);
    wr(ga(2, 2), 16'h0000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_sticky();
        t_w1c();
        t_collision();
        t_sci_route();
        t_smi_steer();
        t_smi_direct();
        t_ext();
        t_no_enable();
        t_readback();
      end
      begin
        repeat (20000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule